// File: doc/BRIEF.md
# Paged Memory Window Mapper

This block translates a 16-bit processor address into a 22-bit physical memory address and decides, for every access, whether it lands in ROM or RAM and whether a write may reach memory. Two page registers and one configuration register, loaded through a small register-write port, steer the translation. The lower half of the processor space (0000-7FFF) is fixed. The upper half (8000-FFFF) is a paged window. In normal mode the whole upper half is one 32 KB page. In extended mode it is split into two independent 16 KB windows.

The address is sorted into one of four regions by its two top bits: `RGN_LOW_FIXED` (0000-3FFF), `RGN_LOW_RAM` (4000-7FFF), `RGN_WIN_A` (8000-BFFF) and `RGN_WIN_B` (C000-FFFF). The region picks the rule for that access. The choice among regions is combinational and leaves no state behind. The register file is the only stored state. A register update commits at the clock edge that samples the write strobe. The configuration register also carries a two-bit clock-choice field, which is decoded into a one-hot select.

Top module: `mw_mapper`

## Requirements
- R1: After reset both page registers and the configuration register are 0. In that state `cfg_rdata` is 0, `clk_choice` is 4'b0001, and address 8000 maps to physical 0 with `rom_sel` high.
- R2: In normal mode (config bit 3 = 0), an address in 8000-FFFF maps to {page A bits 6:0, address bits 14:0}. Bit 7 of page A has no effect.
- R3: In extended mode (config bit 3 = 1), 8000-BFFF maps to {page A, address bits 13:0} and C000-FFFF maps to {page B, address bits 13:0}.
- R4: An address in 0000-7FFF always maps to {7'b0, address bits 14:0}, in either mode.
- R5: With config bit 0 = 0, `rom_sel` is high for every address outside 4000-7FFF and low inside it. With config bit 0 = 1, `rom_sel` is always low.
- R6: `mem_we` equals `cpu_wr`, except that it is forced low for an access with `rom_sel` high, and also when config bit 1 = 1 and physical address bits 21:15 are all zero.
- R7: `cfg_rdata` returns all 8 bits last written to the configuration register.
- R8: `clk_choice` is one-hot, with bit n set when config bits 5:4 hold n. The codes are 0 = 24 MHz, 1 = 12 MHz, 2 = 20 MHz and 3 = 10 MHz.
- R9: A register write takes effect at the clock edge that samples `reg_wr`. An access presented in the same cycle is translated with the previous register values.
- R10: `reg_sel` selects page A (0), page B (1) or configuration (2). A write with `reg_sel` = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 page A, 1 page B, 2 config, 3 reserved |
| reg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Configuration register readback |
| cpu_addr | input | 16 | Processor address |
| cpu_wr | input | 1 | Processor write request |
| phys_addr | output | 22 | Translated physical address |
| rom_sel | output | 1 | High: access goes to ROM, low: RAM |
| mem_we | output | 1 | Gated memory write enable |
| clk_choice | output | 4 | One-hot clock choice decoded from config bits 5:4 |

## Verification
A register update and an address translation can fall in the same cycle. A write that flips the mode, the ROM disable or the protect bit may arrive together with an access whose result depends on that bit. The bench provokes this by raising `reg_wr` and presenting the address in one cycle. It checks that the outputs just before the edge still follow the old settings and that the outputs just after the edge follow the new ones. Random runs mix register writes, including ones to the reserved select, with accesses spread over all four regions. Every result is compared against a bench model of the mapping rules.

// File: rtl/mw_pkg.sv
package mw_pkg;

    // Configuration layout is fixed: neighbouring logic decodes these bits
    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        RGN_LOW_FIXED = 2'b00,
        RGN_LOW_RAM   = 2'b01,
        RGN_WIN_A     = 2'b10,
        RGN_WIN_B     = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        SEL_PAGE_A = 2'd0,
        SEL_PAGE_B = 2'd1,
        SEL_CFG    = 2'd2,
        SEL_RSVD   = 2'd3
    } regsel_e;

    typedef struct packed {
        logic       spare7;
        logic       spare6;
        logic [1:0] clk_code;
        logic       ext_mode;
        logic       spare2;
        logic       ram_prot;
        logic       no_rom;
    } cfg_t;

endpackage

// File: rtl/mw_regs.sv
module mw_regs
    import mw_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  regsel_e           sel,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page_a,
    output logic [PAGE_W-1:0] page_b,
    output cfg_t              cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_a <= '0;
            page_b <= '0;
            cfg    <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_PAGE_A: page_a <= wdata;
                SEL_PAGE_B: page_b <= wdata;
                SEL_CFG:    cfg    <= cfg_t'(wdata[CFG_W-1:0]);
                SEL_RSVD:   ;
            endcase
        end
    end

endmodule

// File: rtl/mw_region.sv
module mw_region
    import mw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    always_comb begin
        region = region_e'(addr[ADDR_W-1 -: 2]);
    end

endmodule

// File: rtl/mw_addr_gen.sv
module mw_addr_gen
    import mw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PHYS_W = 22,
    parameter int PAGE_W = 8
) (
    input  region_e           region,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page_a,
    input  logic [PAGE_W-1:0] page_b,
    input  logic              ext_mode,
    output logic [PHYS_W-1:0] phys
);

    localparam int BIG_OFF  = ADDR_W - 1;
    localparam int SMALL_OFF = ADDR_W - 2;
    localparam int BIG_PG   = PHYS_W - BIG_OFF;
    localparam int SMALL_PG = PHYS_W - SMALL_OFF;

    logic [PHYS_W-1:0] fixed_addr;
    logic [PHYS_W-1:0] big_addr;
    logic [PHYS_W-1:0] small_a_addr;
    logic [PHYS_W-1:0] small_b_addr;

    always_comb begin
        fixed_addr   = {{BIG_PG{1'b0}}, addr[BIG_OFF-1:0]};
        big_addr     = {page_a[BIG_PG-1:0], addr[BIG_OFF-1:0]};
        small_a_addr = {page_a[SMALL_PG-1:0], addr[SMALL_OFF-1:0]};
        small_b_addr = {page_b[SMALL_PG-1:0], addr[SMALL_OFF-1:0]};
    end

    always_comb begin
        unique case (region)
            RGN_LOW_FIXED: phys = fixed_addr;
            RGN_LOW_RAM:   phys = fixed_addr;
            RGN_WIN_A:     phys = ext_mode ? small_a_addr : big_addr;
            RGN_WIN_B:     phys = ext_mode ? small_b_addr : big_addr;
        endcase
    end

endmodule

// File: rtl/mw_access.sv
module mw_access
    import mw_pkg::*;
#(
    parameter int PHYS_W = 22,
    parameter int ADDR_W = 16,
    parameter int CLK_N  = 4
) (
    input  region_e           region,
    input  cfg_t              cfg,
    input  logic [PHYS_W-1:0] phys,
    input  logic              cpu_wr,
    output logic              rom_sel,
    output logic              mem_we,
    output logic [CLK_N-1:0]  clk_choice
);

    localparam int BIG_OFF = ADDR_W - 1;

    logic page0_hit;

    always_comb begin
        unique case (region)
            RGN_LOW_RAM:   rom_sel = 1'b0;
            RGN_LOW_FIXED,
            RGN_WIN_A,
            RGN_WIN_B:     rom_sel = !cfg.no_rom;
        endcase
    end

    always_comb begin
        page0_hit = (phys[PHYS_W-1:BIG_OFF] == '0);
        mem_we    = cpu_wr && !rom_sel && !(cfg.ram_prot && page0_hit);
    end

    for (genvar gi = 0; gi < CLK_N; gi++) begin : g_clk
        assign clk_choice[gi] = (cfg.clk_code == gi[1:0]);
    end

endmodule

// File: rtl/mw_mapper.sv
module mw_mapper
    import mw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PHYS_W = 22,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [PAGE_W-1:0] reg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              rom_sel,
    output logic              mem_we,
    output logic [3:0]        clk_choice
);

    localparam int CLK_N = 4;

    logic [PAGE_W-1:0] page_a;
    logic [PAGE_W-1:0] page_b;
    cfg_t              cfg;
    region_e           region;

    mw_regs #(.PAGE_W(PAGE_W)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .sel    (regsel_e'(reg_sel)),
        .wdata  (reg_wdata),
        .page_a (page_a),
        .page_b (page_b),
        .cfg    (cfg)
    );

    mw_region #(.ADDR_W(ADDR_W)) region_i (
        .addr   (cpu_addr),
        .region (region)
    );

    mw_addr_gen #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W)) addr_i (
        .region   (region),
        .addr     (cpu_addr),
        .page_a   (page_a),
        .page_b   (page_b),
        .ext_mode (cfg.ext_mode),
        .phys     (phys_addr)
    );

    mw_access #(.PHYS_W(PHYS_W), .ADDR_W(ADDR_W), .CLK_N(CLK_N)) access_i (
        .region     (region),
        .cfg        (cfg),
        .phys       (phys_addr),
        .cpu_wr     (cpu_wr),
        .rom_sel    (rom_sel),
        .mem_we     (mem_we),
        .clk_choice (clk_choice)
    );

    assign cfg_rdata = cfg;

endmodule

// File: rtl/mw_mapper_chk.sv
module mw_mapper_chk #(
    parameter int ADDR_W = 16,
    parameter int PHYS_W = 22,
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [PAGE_W-1:0] reg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              rom_sel,
    input logic              mem_we,
    input logic [3:0]        clk_choice
);

    // R4
    low_fixed_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[ADDR_W-1] |-> (phys_addr == {{(PHYS_W-ADDR_W+1){1'b0}}, cpu_addr[ADDR_W-2:0]}));

    // R5
    norom_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] |-> !rom_sel);

    // R6
    rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> !mem_we);

    // R6
    protect_page0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1] && phys_addr[PHYS_W-1:ADDR_W-1] == '0) |-> !mem_we);

    // R6
    no_req_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> !mem_we);

    // R7
    cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2) |=> (cfg_rdata == $past(reg_wdata[7:0])));

    // R8
    clk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(clk_choice) == 1);

    // R10
    rsvd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd3) |=> $stable(cfg_rdata));

endmodule

bind mw_mapper mw_mapper_chk #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W)) chk_i (.*);

// File: tb/mw_mapper_tb_top.sv
module mw_mapper_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  cfg_rdata;
    logic [15:0] cpu_addr = 16'd0;
    logic        cpu_wr = 1'b0;
    logic [21:0] phys_addr;
    logic        rom_sel;
    logic        mem_we;
    logic [3:0]  clk_choice;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench copy of the programmed registers
    logic [7:0] m_pa = 8'd0;
    logic [7:0] m_pb = 8'd0;
    logic [7:0] m_cfg = 8'd0;

    always #(CLK_P/2) clk = ~clk;

    mw_mapper dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cpu_addr   (cpu_addr),
        .cpu_wr     (cpu_wr),
        .phys_addr  (phys_addr),
        .rom_sel    (rom_sel),
        .mem_we     (mem_we),
        .clk_choice (clk_choice)
    );

    function automatic logic [21:0] f_phys(logic [15:0] a, logic [7:0] pa, logic [7:0] pb, logic [7:0] c);
        if (!a[15])     return {7'd0, a[14:0]};
        else if (c[3])  return a[14] ? {pb, a[13:0]} : {pa, a[13:0]};
        else            return {pa[6:0], a[14:0]};
    endfunction

    function automatic logic f_rom(logic [15:0] a, logic [7:0] c);
        return !c[0] && (a[15:14] != 2'b01);
    endfunction

    function automatic logic f_we(logic [15:0] a, logic w, logic [7:0] pa, logic [7:0] pb, logic [7:0] c);
        logic [21:0] p;
        p = f_phys(a, pa, pb, c);
        return w && !f_rom(a, c) && !(c[1] && p[21:15] == 7'd0);
    endfunction

    function automatic logic [3:0] f_clk(logic [7:0] c);
        return 4'b0001 << c[5:4];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // all outputs against the model with the currently presented access
    task automatic check_access(string tag, logic [15:0] a, logic w);
        @(negedge clk);
        cpu_addr = a;
        cpu_wr   = w;
        #1;
        check({tag, " phys"}, 32'(phys_addr), 32'(f_phys(a, m_pa, m_pb, m_cfg)));
        check({tag, " R5 rom"}, 32'(rom_sel), 32'(f_rom(a, m_cfg)));
        check({tag, " R6 we"}, 32'(mem_we), 32'(f_we(a, w, m_pa, m_pb, m_cfg)));
    endtask

    task automatic write_reg(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk);
        case (sel)
            2'd0: m_pa = d;
            2'd1: m_pb = d;
            2'd2: m_cfg = d;
            default: ;
        endcase
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_cfg_out(string tag);
        #1;
        check({tag, " R7 cfg"}, 32'(cfg_rdata), 32'(m_cfg));
        check({tag, " R8 clk"}, 32'(clk_choice), 32'(f_clk(m_cfg)));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_wr = 1'b0;
        #1;
        check("R1 cfg", 32'(cfg_rdata), 32'h0);
        check("R1 clk", 32'(clk_choice), 32'h1);
        check("R1 phys", 32'(phys_addr), 32'h0);
        check("R1 rom", 32'(rom_sel), 32'h1);

        // R2 normal mode, page bit 7 ignored
        write_reg(2'd0, 8'hFF);
        check_access("R2 top", 16'hFFFF, 1'b0);
        check("R2 max", 32'(phys_addr), 32'h3FFFFF);
        write_reg(2'd0, 8'h80);
        check_access("R2 bit7", 16'h8000, 1'b0);
        check("R2 bit7 zero", 32'(phys_addr), 32'h0);

        // R3 extended mode, two windows
        write_reg(2'd2, 8'h09);
        write_reg(2'd0, 8'h12);
        write_reg(2'd1, 8'hAB);
        check_access("R3 winA", 16'h8123, 1'b1);
        check("R3 winA val", 32'(phys_addr), {10'd0, 8'h12, 14'h0123});
        check_access("R3 winB", 16'hC456, 1'b1);
        check("R3 winB val", 32'(phys_addr), {10'd0, 8'hAB, 14'h0456});

        // R4 low region unaffected by pages and mode
        check_access("R4 low", 16'h7ABC, 1'b1);
        check("R4 low val", 32'(phys_addr), 32'h7ABC);

        // R5 ROM mapping with no_rom clear
        write_reg(2'd2, 8'h00);
        check_access("R5 rom low", 16'h0010, 1'b1);
        check_access("R5 ram 4000", 16'h4000, 1'b1);
        check_access("R5 rom win", 16'hC000, 1'b1);

        // R6 protection of lowest 32 KB, including small page 1 in extended mode
        write_reg(2'd2, 8'h03);
        check_access("R6 prot low", 16'h1000, 1'b1);
        check("R6 low blocked", 32'(mem_we), 32'h0);
        write_reg(2'd0, 8'h01);
        check_access("R6 page1 big", 16'h8000, 1'b1);
        check("R6 page1 big ok", 32'(mem_we), 32'h1);
        write_reg(2'd2, 8'h0B);
        check_access("R6 small1", 16'h8000, 1'b1);
        check("R6 small1 blocked", 32'(mem_we), 32'h0);

        // R8 every clock code
        for (int k = 0; k < 4; k++) begin
            write_reg(2'd2, 8'(k << 4));
            check_cfg_out("R8 code");
        end

        // R9 register write and access in the same cycle
        write_reg(2'd2, 8'h00);
        @(negedge clk);
        cpu_addr = 16'h0000; cpu_wr = 1'b1;
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h01;
        #1;
        check("R9 old rom", 32'(rom_sel), 32'h1);
        check("R9 old we", 32'(mem_we), 32'h0);
        @(posedge clk);
        m_cfg = 8'h01;
        #1;
        check("R9 new rom", 32'(rom_sel), 32'h0);
        check("R9 new we", 32'(mem_we), 32'h1);
        @(negedge clk);
        reg_wr = 1'b0;

        // R10 reserved select changes nothing
        write_reg(2'd2, 8'h5A);
        write_reg(2'd0, 8'h33);
        write_reg(2'd3, 8'hFF);
        check_cfg_out("R10 rsvd");
        check_access("R10 rsvd page", 16'h8001, 1'b0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] s;
            logic [7:0] d;
            s = 2'($urandom_range(0, 3));
            d = 8'($urandom());
            write_reg(s, d);
            check_cfg_out("R7 rnd");
            for (int j = 0; j < 3; j++) begin
                logic [15:0] a;
                a = 16'($urandom());
                check_access(!a[15] ? "R4 rnd" : (m_cfg[3] ? "R3 rnd" : "R2 rnd"), a, 1'($urandom()));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule